// File: doc/BRIEF.md
# Lookup-Based Row Reduction Engine

This block reduces every row of a streamed, rotated greyscale image to a single 32-bit value, for four rotation lanes at once. Each cycle one pixel and one mask bit per lane arrive together with row-start and row-end strobes shared by all lanes. Each pixel is mapped through a runtime-writable forward table. In difference mode, a second table is applied to the same lane's previous pixel, and the absolute difference of the two looked-up values is used instead. The per-pixel terms of unmasked pixels are summed across the row. At the end of the row the sum can be squared.

Software-visible behaviour is set entirely through the two tables and a two-bit configuration register. Changing the reduction function therefore needs no new hardware. All four lanes have their own datapath and share one control path. One cycle after a row ends, a result per lane is presented together with a one-cycle ready pulse.

Top module: `rowfn_top`

## Requirements
- R1: In plain mode (config bit 0 = 0), each unmasked pixel of a lane adds the forward table entry indexed by its 8-bit value to that lane's row sum. Table entries are 16 bits wide.
- R2: In difference mode (config bit 0 = 1), each unmasked pixel that is not the first of its row adds |fwd(p[t]) − prev_tbl(p[t−1])|. Here p[t−1] is the lane's previous pixel in the same row, taken whatever its mask bit.
- R3: In difference mode, the first pixel of a row (row_first_i = 1) adds zero, including a row of a single pixel.
- R4: A pixel whose mask bit is 0 adds zero to its lane's sum.
- R5: With config bit 1 = 1, the reported result is the square of the final row sum, taken modulo 2^32. With that bit at 0, the reported result is the sum itself.
- R6: The cycle after the clock edge that accepts a pixel with row_last_i = 1, res_rdy_o is high for exactly one cycle and res_o carries every lane's result. res_o keeps that value until the next result.
- R7: The row sum saturates at 0xFFFFFFFF instead of wrapping.
- R8: A table write loads the forward table when lut_sel_i = 0 and the previous-pixel table when lut_sel_i = 1. It takes effect only while the block is idle, that is, no row is open and pix_valid_i is low. Otherwise the write is dropped.
- R9: A configuration write is taken only while idle. A write attempted during a row is dropped, not deferred.
- R10: The lanes are independent: each lane's result depends only on its own pixels and masks. After reset, res_o = 0, res_rdy_o = 0, the configuration is 0 and every table entry is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | A pixel beat is present on all lanes |
| row_first_i | input | 1 | Beat is the first pixel of a row |
| row_last_i | input | 1 | Beat is the last pixel of a row |
| pix_i | input | 32 | Four 8-bit pixels; lane n at bits 8n+7:8n |
| mask_i | input | 4 | Per-lane mask; 0 excludes the pixel |
| lut_we_i | input | 1 | Table write strobe |
| lut_sel_i | input | 1 | 0 forward table, 1 previous-pixel table |
| lut_addr_i | input | 8 | Table entry index |
| lut_data_i | input | 16 | Table entry value |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_i | input | 2 | Bit 0 difference mode, bit 1 square result |
| res_o | output | 128 | Four 32-bit row results; lane n at bits 32n+31:32n |
| res_rdy_o | output | 1 | One-cycle pulse: res_o holds new results |

## Verification
Two events can fall in the same cycle: the result pulse for one row and the first beat of the next row. The bench provokes this by sending two rows back to back. In the overlapping cycle it also attempts a table write and a configuration write. It judges the outcome in three ways: the first row's results must appear intact during the pulse, the second row's sums must match a model in which neither write happened, and a later idle-time row must show that both the table entry and the mode are unchanged.

// File: rtl/rowfn_pkg.sv
package rowfn_pkg;
  typedef struct packed {
    logic square;  // bit 1
    logic diff;    // bit 0
  } cfg_t;

  typedef enum logic {
    TBL_FWD  = 1'b0,
    TBL_PREV = 1'b1
  } tbl_sel_e;
endpackage

// File: rtl/rowfn_lut.sv
module rowfn_lut #(
  parameter int LANES = 4,
  parameter int PIX_W = 8,
  parameter int LUT_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  rowfn_pkg::tbl_sel_e    wr_sel_i,
  input  logic [PIX_W-1:0]       wr_addr_i,
  input  logic [LUT_W-1:0]       wr_data_i,
  input  logic [LANES*PIX_W-1:0] fwd_addr_i,
  input  logic [LANES*PIX_W-1:0] prev_addr_i,
  output logic [LANES*LUT_W-1:0] fwd_data_o,
  output logic [LANES*LUT_W-1:0] prev_data_o
);
  localparam int DEPTH = 1 << PIX_W;

  logic [LUT_W-1:0] fwd_q  [DEPTH];
  logic [LUT_W-1:0] prev_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        fwd_q[i]  <= '0;
        prev_q[i] <= '0;
      end
    end else if (wr_en_i) begin
      if (wr_sel_i == rowfn_pkg::TBL_FWD) fwd_q[wr_addr_i]  <= wr_data_i;
      else                                prev_q[wr_addr_i] <= wr_data_i;
    end
  end

  // one read port per lane on each table
  for (genvar l = 0; l < LANES; l++) begin : g_rd
    assign fwd_data_o[l*LUT_W +: LUT_W]  = fwd_q[fwd_addr_i[l*PIX_W +: PIX_W]];
    assign prev_data_o[l*LUT_W +: LUT_W] = prev_q[prev_addr_i[l*PIX_W +: PIX_W]];
  end
endmodule

// File: rtl/rowfn_ctrl.sv
module rowfn_ctrl (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             first_i,
  input  logic             last_i,
  input  logic             lut_we_i,
  input  logic             cfg_we_i,
  input  rowfn_pkg::cfg_t  cfg_i,
  output logic             lut_wr_en_o,
  output rowfn_pkg::cfg_t  cfg_o,
  output logic             in_row_o,
  output logic             has_prev_o,
  output logic             start_o,
  output logic             step_o,
  output logic             done_o,
  output logic             rdy_o
);
  logic            in_row_q;
  logic            rdy_q;
  logic            busy;
  rowfn_pkg::cfg_t cfg_q;

  assign busy = in_row_q | valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_row_q <= 1'b0;
      rdy_q    <= 1'b0;
      cfg_q    <= '0;
    end else begin
      if (valid_i) in_row_q <= ~last_i;
      rdy_q <= valid_i & last_i;
      if (cfg_we_i && !busy) cfg_q <= cfg_i;
    end
  end

  assign lut_wr_en_o = lut_we_i & ~busy;
  assign cfg_o       = cfg_q;
  assign in_row_o    = in_row_q;
  assign has_prev_o  = in_row_q & ~first_i;
  assign start_o     = valid_i & first_i;
  assign step_o      = valid_i;
  assign done_o      = valid_i & last_i;
  assign rdy_o       = rdy_q;
endmodule

// File: rtl/rowfn_lane.sv
module rowfn_lane #(
  parameter int PIX_W = 8,
  parameter int LUT_W = 16,
  parameter int ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             mask_i,
  input  logic             step_i,
  input  logic             start_i,
  input  logic             done_i,
  input  logic             has_prev_i,
  input  rowfn_pkg::cfg_t  cfg_i,
  input  logic [LUT_W-1:0] fwd_val_i,
  input  logic [LUT_W-1:0] prev_val_i,
  output logic [PIX_W-1:0] prev_pix_o,
  output logic [ACC_W-1:0] acc_o,
  output logic [ACC_W-1:0] res_o
);
  logic [PIX_W-1:0] prev_q;
  logic [ACC_W-1:0] acc_q, res_q;
  logic [LUT_W-1:0] abs_diff, term;
  logic [ACC_W-1:0] acc_base, acc_nxt, sq;
  logic [ACC_W:0]   sum;

  assign abs_diff = (fwd_val_i >= prev_val_i) ? fwd_val_i - prev_val_i
                                              : prev_val_i - fwd_val_i;

  always_comb begin
    if (!mask_i)          term = '0;
    else if (!cfg_i.diff) term = fwd_val_i;
    else if (!has_prev_i) term = '0;
    else                  term = abs_diff;
  end

  assign acc_base = start_i ? '0 : acc_q;
  assign sum      = {1'b0, acc_base} + {{(ACC_W + 1 - LUT_W){1'b0}}, term};
  assign acc_nxt  = sum[ACC_W] ? {ACC_W{1'b1}} : sum[ACC_W-1:0];
  assign sq       = acc_nxt * acc_nxt;  // low ACC_W bits of the square

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      acc_q  <= '0;
      res_q  <= '0;
    end else if (step_i) begin
      prev_q <= pix_i;
      acc_q  <= acc_nxt;
      if (done_i) res_q <= cfg_i.square ? sq : acc_nxt;
    end
  end

  assign prev_pix_o = prev_q;
  assign acc_o      = acc_q;
  assign res_o      = res_q;
endmodule

// File: rtl/rowfn_top.sv
module rowfn_top #(
  parameter int LANES = 4,
  parameter int PIX_W = 8,
  parameter int LUT_W = 16,
  parameter int ACC_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   pix_valid_i,
  input  logic                   row_first_i,
  input  logic                   row_last_i,
  input  logic [LANES*PIX_W-1:0] pix_i,
  input  logic [LANES-1:0]       mask_i,
  input  logic                   lut_we_i,
  input  logic                   lut_sel_i,
  input  logic [PIX_W-1:0]       lut_addr_i,
  input  logic [LUT_W-1:0]       lut_data_i,
  input  logic                   cfg_we_i,
  input  logic [1:0]             cfg_i,
  output logic [LANES*ACC_W-1:0] res_o,
  output logic                   res_rdy_o
);
  logic                   lut_wr_en, in_row, has_prev, start, step, done;
  rowfn_pkg::cfg_t        cfg_cur;
  logic [LANES*PIX_W-1:0] prev_pix;
  logic [LANES*LUT_W-1:0] fwd_val, prev_val;
  logic [LANES*ACC_W-1:0] acc_all;

  rowfn_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (pix_valid_i),
    .first_i    (row_first_i),
    .last_i     (row_last_i),
    .lut_we_i   (lut_we_i),
    .cfg_we_i   (cfg_we_i),
    .cfg_i      (rowfn_pkg::cfg_t'(cfg_i)),
    .lut_wr_en_o(lut_wr_en),
    .cfg_o      (cfg_cur),
    .in_row_o   (in_row),
    .has_prev_o (has_prev),
    .start_o    (start),
    .step_o     (step),
    .done_o     (done),
    .rdy_o      (res_rdy_o)
  );

  rowfn_lut #(.LANES(LANES), .PIX_W(PIX_W), .LUT_W(LUT_W)) u_lut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (lut_wr_en),
    .wr_sel_i   (rowfn_pkg::tbl_sel_e'(lut_sel_i)),
    .wr_addr_i  (lut_addr_i),
    .wr_data_i  (lut_data_i),
    .fwd_addr_i (pix_i),
    .prev_addr_i(prev_pix),
    .fwd_data_o (fwd_val),
    .prev_data_o(prev_val)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    rowfn_lane #(.PIX_W(PIX_W), .LUT_W(LUT_W), .ACC_W(ACC_W)) u_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pix_i     (pix_i[l*PIX_W +: PIX_W]),
      .mask_i    (mask_i[l]),
      .step_i    (step),
      .start_i   (start),
      .done_i    (done),
      .has_prev_i(has_prev),
      .cfg_i     (cfg_cur),
      .fwd_val_i (fwd_val[l*LUT_W +: LUT_W]),
      .prev_val_i(prev_val[l*LUT_W +: LUT_W]),
      .prev_pix_o(prev_pix[l*PIX_W +: PIX_W]),
      .acc_o     (acc_all[l*ACC_W +: ACC_W]),
      .res_o     (res_o[l*ACC_W +: ACC_W])
    );
  end
endmodule

// File: rtl/rowfn_checker.sv
module rowfn_checker #(
  parameter int LANES = 4,
  parameter int ACC_W = 32
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   pix_valid_i,
  input logic                   row_first_i,
  input logic                   row_last_i,
  input logic [LANES-1:0]       mask_i,
  input logic                   in_row_i,
  input logic                   diff_i,
  input logic [LANES*ACC_W-1:0] acc_all_i,
  input logic [LANES*ACC_W-1:0] res_o,
  input logic                   res_rdy_o
);
  a_r6_rdy_follows_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_i && row_last_i |=> res_rdy_o);

  a_r6_rdy_only_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_rdy_o |-> $past(pix_valid_i && row_last_i));

  a_r6_res_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_rdy_o |-> $stable(res_o));

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    a_r3_first_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pix_valid_i && row_first_i && diff_i |=> acc_all_i[l*ACC_W +: ACC_W] == '0);

    a_r4_masked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pix_valid_i && !row_first_i && in_row_i && !mask_i[l]
      |=> $stable(acc_all_i[l*ACC_W +: ACC_W]));

    a_r7_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pix_valid_i && !row_first_i && in_row_i
      |=> acc_all_i[l*ACC_W +: ACC_W] >= $past(acc_all_i[l*ACC_W +: ACC_W]));
  end
endmodule

bind rowfn_top rowfn_checker #(.LANES(LANES), .ACC_W(ACC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pix_valid_i(pix_valid_i),
  .row_first_i(row_first_i),
  .row_last_i (row_last_i),
  .mask_i     (mask_i),
  .in_row_i   (in_row),
  .diff_i     (cfg_cur.diff),
  .acc_all_i  (acc_all),
  .res_o      (res_o),
  .res_rdy_o  (res_rdy_o)
);

// File: tb/rowfn_top_bench.sv
`timescale 1ns/1ps
module rowfn_top_bench;
  localparam longint MAXV = 64'hFFFF_FFFF;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pix_valid = 0, row_first = 0, row_last = 0;
  logic [31:0]  pix = '0;
  logic [3:0]   mask = '0;
  logic         lut_we = 0, lut_sel = 0;
  logic [7:0]   lut_addr = '0;
  logic [15:0]  lut_data = '0;
  logic         cfg_we = 0;
  logic [1:0]   cfg = '0;
  logic [127:0] res;
  logic         res_rdy;

  int n_tests = 0, n_fail = 0;
  int l1m [256];
  int l2m [256];
  bit m_diff = 0, m_sq = 0;
  logic [31:0] exp_res [4];
  int inj_addr = 0;

  always #2.5 clk = ~clk;

  rowfn_top u_rowfn_top (
    .clk_i(clk), .rst_ni(rst_n), .pix_valid_i(pix_valid), .row_first_i(row_first),
    .row_last_i(row_last), .pix_i(pix), .mask_i(mask), .lut_we_i(lut_we),
    .lut_sel_i(lut_sel), .lut_addr_i(lut_addr), .lut_data_i(lut_data),
    .cfg_we_i(cfg_we), .cfg_i(cfg), .res_o(res), .res_rdy_o(res_rdy)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic longint f_term(int p, int pv, bit hp, bit m);
    int d;
    if (!m) return 0;
    if (!m_diff) return l1m[p];
    if (!hp) return 0;
    d = l1m[p] - l2m[pv];
    return (d < 0) ? -d : d;
  endfunction

  task automatic lut_write(bit sel, int addr, int data);
    lut_we = 1; lut_sel = sel; lut_addr = addr[7:0]; lut_data = data[15:0];
    @(posedge clk); #1;
    lut_we = 0;
    if (sel) l2m[addr] = data; else l1m[addr] = data;
  endtask

  task automatic cfg_write(bit d, bit s);
    cfg_we = 1; cfg = {s, d};
    @(posedge clk); #1;
    cfg_we = 0;
    m_diff = d; m_sq = s;
  endtask

  // mmode: 0 random masks, 1 all set, 2 lane0 set / lane1 clear / others random
  task automatic run_row(int len, int fixed_pix, int mmode, bit inj);
    longint acc [4];
    int prv [4];
    for (int l = 0; l < 4; l++) begin acc[l] = 0; prv[l] = 0; end
    for (int i = 0; i < len; i++) begin
      for (int l = 0; l < 4; l++) begin
        int p;
        bit m;
        p = (fixed_pix >= 0) ? fixed_pix : int'($urandom_range(0, 255));
        case (mmode)
          0: m = $urandom_range(0, 1);
          1: m = 1;
          default: m = (l == 0) ? 1'b1 : (l == 1) ? 1'b0 : 1'($urandom_range(0, 1));
        endcase
        acc[l] = acc[l] + f_term(p, prv[l], i > 0, m);
        if (acc[l] > MAXV) acc[l] = MAXV;
        prv[l] = p;
        pix[l*8 +: 8] = p[7:0];
        mask[l] = m;
      end
      pix_valid = 1; row_first = (i == 0); row_last = (i == len - 1);
      if (inj && i == 0) begin
        inj_addr = pix[7:0];
        lut_we = 1; lut_sel = 0; lut_addr = pix[7:0]; lut_data = ~l1m[inj_addr][15:0];
        cfg_we = 1; cfg = ~{m_sq, m_diff};
      end
      @(posedge clk); #1;
      lut_we = 0; cfg_we = 0;
    end
    pix_valid = 0; row_first = 0; row_last = 0;
    for (int l = 0; l < 4; l++)
      exp_res[l] = m_sq ? 32'(acc[l] * acc[l]) : acc[l][31:0];
  endtask

  task automatic check_res(string req);
    chk(req, "res_rdy", {31'd0, res_rdy}, 32'd1);
    for (int l = 0; l < 4; l++) chk(req, $sformatf("lane%0d", l), res[l*32 +: 32], exp_res[l]);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R6 watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [127:0] held;
    void'($urandom(32'd7321));
    for (int a = 0; a < 256; a++) begin l1m[a] = 0; l2m[a] = 0; end
    #12;
    // R10 reset state
    chk("R10", "reset res lane0", res[31:0], 32'd0);
    chk("R10", "reset res lane3", res[127:96], 32'd0);
    chk("R10", "reset rdy", {31'd0, res_rdy}, 32'd0);
    @(posedge clk); #1; rst_n = 1;
    @(posedge clk); #1;

    // R10 tables cleared by reset
    run_row(8, -1, 1, 0); check_res("R10");

    for (int a = 0; a < 256; a++) begin
      lut_write(0, a, int'($urandom_range(0, 65535)));
      lut_write(1, a, int'($urandom_range(0, 65535)));
    end

    // R1 / R4 plain mode
    run_row(16, -1, 1, 0); check_res("R1");
    run_row(20, -1, 0, 0); check_res("R4");
    run_row(5,  -1, 0, 0); check_res("R4");

    // R6 hold between rows
    held = res;
    repeat (5) @(posedge clk); #1;
    chk("R6", "rdy low while idle", {31'd0, res_rdy}, 32'd0);
    chk("R6", "res held lane0", res[31:0], held[31:0]);
    chk("R6", "res held lane2", res[95:64], held[95:64]);

    // R2 / R3 difference mode
    cfg_write(1, 0);
    run_row(16, -1, 1, 0); check_res("R2");
    run_row(24, -1, 0, 0); check_res("R2");
    run_row(1,  -1, 1, 0); check_res("R3");
    run_row(6,  77, 1, 0); check_res("R3");

    // R5 squaring
    cfg_write(0, 1);
    run_row(10, -1, 0, 0); check_res("R5");
    cfg_write(1, 1);
    run_row(10, -1, 1, 0); check_res("R5");

    // R10 lane independence
    cfg_write(0, 0);
    run_row(12, -1, 2, 0); check_res("R10");

    // back-to-back rows; writes attempted in the overlap cycle (R8, R9)
    cfg_write(1, 0);
    run_row(12, -1, 2, 0); check_res("R6");
    run_row(12, -1, 2, 1); check_res("R9");
    run_row(8, -1, 1, 0);  check_res("R9");
    cfg_write(0, 0);
    run_row(4, inj_addr, 1, 0); check_res("R8");
    lut_write(1, 3, 16'h1234);
    lut_write(0, 9, 16'h0100);
    cfg_write(1, 0);
    run_row(2, -1, 1, 0);
    begin
      // directed: lane pixels 3 then 9 -> |0x100 - 0x1234|
      pix_valid = 1; row_first = 1; row_last = 0; pix = {4{8'd3}}; mask = 4'hF;
      @(posedge clk); #1;
      row_first = 0; row_last = 1; pix = {4{8'd9}};
      @(posedge clk); #1;
      pix_valid = 0; row_last = 0;
      chk("R8", "table select lane0", res[31:0], 32'h1134);
      chk("R8", "table select lane3", res[127:96], 32'h1134);
    end

    // R7 saturation
    lut_write(0, 255, 16'hFFFF);
    cfg_write(0, 0);
    run_row(65540, 255, 1, 0); check_res("R7");
    chk("R7", "saturated value", res[31:0], 32'hFFFF_FFFF);
    cfg_write(0, 1);
    run_row(65540, 255, 1, 0);
    chk("R7", "saturated squared", res[63:32], 32'd1);

    finish_run();
  end
endmodule